// File: doc/BRIEF.md
# Wrapping Log Address Pointer

This block keeps a 24-bit byte address into an external serial flash log. A flash sequencer reads the address, issues its transfer, and then tells the pointer to move. The pointer can move forward by an 8-bit unsigned step or backward by an 8-bit step. A one-cycle strobe starts each move, and an operation code selects its kind. The new value appears on the clock edge that samples the strobe.

There are two forward modes, and each has its own upper-byte limit. When an addition makes the top byte equal the limit, only the top byte is cleared. The lower 16 bits are kept. In the backward direction, any result with bit 23 set is replaced by 0x00FFFF. A unit flag replaces the step with one, which gives the common advance-by-one form. A load port writes the pointer directly. A one-cycle flag reports that the last operation applied a wrap rule.

Top module: `log_addr_ptr`

## Requirements
- R1: While `rst` is high at a clock edge, `ptr` becomes 0x000000 and `wrapped` becomes 0.
- R2: With `op_valid`=1 and `op_sel`=2'b00 (normal increment), the next `ptr` is `ptr` plus the unsigned step, with carry through all 24 bits, unless R3 applies.
- R3: In normal increment, if bit 23..16 of the sum equals 0x40, those bits are cleared to 0x00 and bits 15..0 of the sum are kept.
- R4: With `op_sel`=2'b01 (alternate increment), the rules of R2 and R3 apply with the upper-byte limit 0x20 instead of 0x40. A sum whose top byte is 0x20 does not wrap in normal mode.
- R5: With `op_sel`=2'b10 (decrement), the next `ptr` is `ptr` minus the unsigned step, modulo 2^24, unless R6 applies.
- R6: If bit 23 of the decrement result is set, the next `ptr` is 0x00FFFF.
- R7: When `op_unit`=1, the step is one for every operation and `step` is ignored.
- R8: `load_en`=1 makes the next `ptr` equal `load_val` and the next `wrapped` equal 0. This holds even when a valid operation is strobed in the same cycle.
- R9: `wrapped` is 1 for exactly the cycle after an operation whose result used the R3, R4 or R6 wrap rule. Otherwise it is 0.
- R10: With no load, and with `op_valid`=0 or `op_sel`=2'b11, `ptr` holds its value and `wrapped` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write `load_val` into the pointer |
| load_val | input | 24 | Value to load |
| op_valid | input | 1 | One-cycle operation strobe |
| op_sel | input | 2 | 00 normal increment, 01 alternate increment, 10 decrement, 11 none |
| op_unit | input | 1 | Use a step of one |
| step | input | 8 | Unsigned step amount |
| ptr | output | 24 | Current pointer |
| wrapped | output | 1 | The last operation applied a wrap rule |

## Verification
The bench builds the block with its default parameters: a 24-bit address, an 8-bit step, and limits 0x40 and 0x20. With these values, loaded start points just below each limit reach both wrap rules in one step. A top byte of 0x20 is used in both increment modes, which separates the two limits. Decrements from small values push the result past bit 23, which reaches the 0x00FFFF fill. A load is placed in the same cycle as a strobe to show that the load wins.

// File: rtl/log_addr_ptr_pkg.sv
package log_addr_ptr_pkg;
  typedef enum logic [1:0] {
    OP_INC     = 2'b00,
    OP_INC_ALT = 2'b01,
    OP_DEC     = 2'b10,
    OP_NONE    = 2'b11
  } ptr_op_e;
endpackage

// File: rtl/log_addr_ptr_inc.sv
module log_addr_ptr_inc #(
  parameter int ADDR_W = 24,
  parameter int STEP_W = 8,
  parameter int TOP_W  = 8,
  parameter logic [TOP_W-1:0] LIMIT = 8'h40
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [STEP_W-1:0] amt,
  output logic [ADDR_W-1:0] nxt,
  output logic              wrap
);
  localparam int LOW_W = ADDR_W - TOP_W;

  function automatic logic [ADDR_W-1:0] add_amt(input logic [ADDR_W-1:0] a,
                                                input logic [STEP_W-1:0] s);
    return a + ADDR_W'(s);
  endfunction

  logic [ADDR_W-1:0] sum;

  always_comb begin
    sum  = add_amt(cur, amt);
    wrap = (sum[ADDR_W-1 -: TOP_W] == LIMIT);
    nxt  = wrap ? {{TOP_W{1'b0}}, sum[LOW_W-1:0]} : sum;
  end
endmodule

// File: rtl/log_addr_ptr_dec.sv
module log_addr_ptr_dec #(
  parameter int ADDR_W = 24,
  parameter int STEP_W = 8,
  parameter int TOP_W  = 8
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [STEP_W-1:0] amt,
  output logic [ADDR_W-1:0] nxt,
  output logic              wrap
);
  localparam int LOW_W = ADDR_W - TOP_W;
  localparam logic [ADDR_W-1:0] FILL = {{TOP_W{1'b0}}, {LOW_W{1'b1}}};

  function automatic logic [ADDR_W-1:0] sub_amt(input logic [ADDR_W-1:0] a,
                                                input logic [STEP_W-1:0] s);
    return a - ADDR_W'(s);
  endfunction

  logic [ADDR_W-1:0] diff;

  always_comb begin
    diff = sub_amt(cur, amt);
    wrap = diff[ADDR_W-1];
    nxt  = wrap ? FILL : diff;
  end
endmodule

// File: rtl/log_addr_ptr.sv
module log_addr_ptr
  import log_addr_ptr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int STEP_W = 8,
  parameter int TOP_W  = 8,
  parameter logic [TOP_W-1:0] NORM_LIMIT = 8'h40,
  parameter logic [TOP_W-1:0] ALT_LIMIT  = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              op_valid,
  input  logic [1:0]        op_sel,
  input  logic              op_unit,
  input  logic [STEP_W-1:0] step,
  output logic [ADDR_W-1:0] ptr,
  output logic              wrapped
);
  localparam int N_INC = 2;
  localparam int LOW_W = ADDR_W - TOP_W;

  logic [STEP_W-1:0] eff_step;
  logic [ADDR_W-1:0] inc_nxt [N_INC];
  logic              inc_wrap [N_INC];
  logic [ADDR_W-1:0] dec_nxt;
  logic              dec_wrap;
  logic              op_fire;
  logic [ADDR_W-1:0] sel_nxt;
  logic              sel_wrap;

  assign eff_step = op_unit ? STEP_W'(1) : step;

  for (genvar g = 0; g < N_INC; g++) begin : g_inc
    log_addr_ptr_inc #(
      .ADDR_W(ADDR_W), .STEP_W(STEP_W), .TOP_W(TOP_W),
      .LIMIT ((g == 0) ? NORM_LIMIT : ALT_LIMIT)
    ) u_inc (
      .cur(ptr), .amt(eff_step), .nxt(inc_nxt[g]), .wrap(inc_wrap[g])
    );
  end

  log_addr_ptr_dec #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .TOP_W(TOP_W)) u_dec (
    .cur(ptr), .amt(eff_step), .nxt(dec_nxt), .wrap(dec_wrap)
  );

  always_comb begin
    op_fire  = op_valid && (ptr_op_e'(op_sel) != OP_NONE);
    sel_nxt  = ptr;
    sel_wrap = 1'b0;
    case (ptr_op_e'(op_sel))
      OP_INC:     begin sel_nxt = inc_nxt[0]; sel_wrap = inc_wrap[0]; end
      OP_INC_ALT: begin sel_nxt = inc_nxt[1]; sel_wrap = inc_wrap[1]; end
      OP_DEC:     begin sel_nxt = dec_nxt;    sel_wrap = dec_wrap;    end
      default:    begin sel_nxt = ptr;        sel_wrap = 1'b0;        end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      wrapped <= 1'b0;
    end else if (load_en) begin
      ptr     <= load_val;
      wrapped <= 1'b0;
    end else if (op_fire) begin
      ptr     <= sel_nxt;
      wrapped <= sel_wrap;
    end else begin
      wrapped <= 1'b0;
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (ptr == $past(load_val)) && !wrapped); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!load_en && (!op_valid || op_sel == 2'b11)) |=> $stable(ptr) && !wrapped); // R10

  AST_WRAP_NEEDS_OP: assert property (@(posedge clk) disable iff (rst)
    wrapped |-> $past(op_valid && !load_en && op_sel != 2'b11)); // R9

  AST_DEC_FILL: assert property (@(posedge clk) disable iff (rst)
    (wrapped && $past(op_sel) == 2'b10) |-> ptr == {{TOP_W{1'b0}}, {LOW_W{1'b1}}}); // R6

  AST_INC_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wrapped && $past(op_sel) != 2'b10) |-> ptr[ADDR_W-1 -: TOP_W] == '0); // R3
endmodule

// File: tb/log_addr_ptr_test.sv
module log_addr_ptr_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0;
  logic [23:0] load_val = '0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_sel = 2'b11;
  logic        op_unit = 1'b0;
  logic [7:0]  step = '0;
  logic [23:0] ptr;
  logic        wrapped;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [23:0] exp_ptr_q [$];
  logic        exp_wrap_q [$];
  string       tag_q [$];
  logic [23:0] model_ptr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  log_addr_ptr uut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
    .op_valid(op_valid), .op_sel(op_sel), .op_unit(op_unit), .step(step),
    .ptr(ptr), .wrapped(wrapped)
  );

  task automatic check(string tag, logic [23:0] ep, logic ew);
    n_cmp++;
    if (ptr !== ep || wrapped !== ew) begin
      n_bad++;
      $display("FAIL %s: ptr=%06h wrapped=%0b expected ptr=%06h wrapped=%0b",
               tag, ptr, wrapped, ep, ew);
    end
  endtask

  // Monitor: compares each result two time units after the edge that made it
  always @(posedge clk) begin
    #2;
    if (exp_ptr_q.size() > 0) begin
      logic [23:0] ep;
      logic        ew;
      string       t;
      ep = exp_ptr_q.pop_front();
      ew = exp_wrap_q.pop_front();
      t  = tag_q.pop_front();
      check(t, ep, ew);
    end
  end

  // Driver: drives one cycle of stimulus and pushes its expected outcome
  task automatic drive(input bit ld, input logic [23:0] lv, input bit v,
                       input logic [1:0] sel, input bit unit,
                       input logic [7:0] st, input string tag);
    logic [31:0] amt;
    logic [31:0] v32;
    bit          w;
    @(negedge clk);
    load_en = ld; load_val = lv; op_valid = v; op_sel = sel;
    op_unit = unit; step = st;
    amt = unit ? 32'd1 : {24'd0, st};
    w = 0;
    v32 = {8'd0, model_ptr};
    if (ld) begin
      v32 = {8'd0, lv};
    end else if (v && sel != 2'b11) begin
      if (sel == 2'b10) begin
        v32 = (v32 + 32'h0100_0000 - amt) % 32'h0100_0000;
        if (v32 >= 32'h0080_0000) begin v32 = 32'h0000_FFFF; w = 1; end
      end else begin
        v32 = (v32 + amt) % 32'h0100_0000;
        if (((v32 >> 16) & 32'hFF) == ((sel == 2'b00) ? 32'h40 : 32'h20)) begin
          v32 = v32 & 32'h0000_FFFF; w = 1;
        end
      end
    end
    model_ptr = v32[23:0];
    exp_ptr_q.push_back(model_ptr);
    exp_wrap_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset", 24'h0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    drive(0, 0, 1, 2'b00, 0, 8'h05, "R2 inc 5");
    drive(1, 24'h00FFFE, 1, 2'b10, 0, 8'h09, "R8 load beats strobe");
    drive(0, 0, 1, 2'b00, 0, 8'h03, "R2 carry across bytes");
    drive(1, 24'h3FFFF0, 0, 2'b00, 0, 8'h00, "R8 load");
    drive(0, 0, 1, 2'b00, 0, 8'h20, "R3 normal wrap keeps low bits");
    drive(0, 0, 0, 2'b00, 0, 8'h11, "R9 R10 idle after wrap");
    drive(1, 24'h1FFFFF, 0, 2'b00, 0, 8'h00, "R8 load");
    drive(0, 0, 1, 2'b01, 1, 8'h77, "R4 R7 alt wrap by one");
    drive(1, 24'h1FFFFF, 0, 2'b00, 0, 8'h00, "R8 load");
    drive(0, 0, 1, 2'b00, 0, 8'h01, "R4 0x20 no wrap in normal mode");
    drive(1, 24'h3FFF00, 0, 2'b00, 0, 8'h00, "R8 load");
    drive(0, 0, 1, 2'b01, 0, 8'hFF, "R4 alt no wrap above limit");
    drive(1, 24'h010000, 0, 2'b00, 0, 8'h00, "R8 load");
    drive(0, 0, 1, 2'b10, 0, 8'h01, "R5 dec with borrow");
    drive(0, 0, 1, 2'b10, 1, 8'h80, "R7 dec by unit");
    drive(0, 0, 1, 2'b11, 0, 8'h40, "R10 none code holds");
    drive(1, 24'h000003, 0, 2'b00, 0, 8'h00, "R8 load");
    drive(0, 0, 1, 2'b10, 0, 8'h05, "R6 dec below zero fills");
    drive(0, 0, 1, 2'b10, 0, 8'h10, "R5 dec after fill");
    drive(0, 0, 0, 2'b10, 0, 8'h10, "R9 R10 no strobe");
    drive(0, 0, 0, 2'b00, 0, 8'h00, "R10 idle");
    repeat (4) @(posedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule